// File: doc/BRIEF.md
# Secure System Control Register File

This block is a bus slave that owns a 4 KB window of 32-bit control and status words. These words are used by secure firmware on a small processor subsystem. Firmware uses it to read and modify a secure-debug status word through separate set and clear aliases, and to request a system reset. It also uses the block to record the cause of the last reset, to keep one word across ordinary resets, and to hold clock-divider, clock-force and power-domain sense settings for neighbouring logic. A power-control word has a self-locking write gate. A fixed identification area sits at the top of the window.

A build parameter `VARIANT` (0, 1 or 2) decides which offsets exist and which ones carry storage. An offset that does not exist in the chosen variant reads as zero, ignores writes and flags an access error.

The bus is APB-like, with zero wait states. Narrow accesses reach the block as full words with zero-padded data. Clock division, power sensing and reset generation are not done here: the block only stores the settings. It emits a one-cycle reset request.

Top module: `sysctl_regfile`

## Requirements
- R1: After `rst_n` is released, these offsets read as follows: 0x100 reads 1, 0x1FC reads 3 (variant 2), 0x200 reads 0x7F (variants 1 and 2). Offset 0x000 and every other stored word read 0.
- R2: Offset 0x000 is read-only debug status. A write to 0x004 ORs the write data into it. A write to 0x008 clears each bit that is 1 in the write data.
- R3: A read of 0x004, 0x008 or 0x108 returns 0 and raises the error.
- R4: A write to 0x108 with bit 9 set makes `sys_rst_req` high for exactly the one cycle after the access. Writes to 0x108 with bit 9 clear have no effect.
- R5: The word at 0x10C is cleared only by `por_n`. It keeps its value across `rst_n`, while the other words return to their reset values.
- R6: In variant 2, a write to 0x1FC is stored only while the current bit 0 of that word is 1. Otherwise the write is dropped and no error is raised.
- R7: Offsets 0xFD0 to 0xFFC are read-only and return one byte each: 04 00 00 00 54 B8 xx 00 0D F0 05 B1 in rising address order. Here xx is 0x0B in variant 0 and 0x1B otherwise. A write there raises the error.
- R8: In variant 0, offsets 0x00C, 0x010, 0x014, 0x018 and 0x200 do not exist. Reads return 0, writes are dropped, and the error is raised.
- R9: In variant 0, offset 0x11C reads 0 with no error. A write to it raises the error.
- R10: Offsets 0x20C, 0x210 and 0x11C hold storage only in variant 1. Offset 0x204 holds storage only in variant 2. Offsets 0x214 and 0x218 hold storage in variants 1 and 2. Where they do not exist, they behave as in R8.
- R11: Offsets 0x00C, 0x010, 0x014, 0x018, 0x100 and 0x104 (where present) read back the last full word written.
- R12: `pslverr` and `err_pulse` are high only in the access phase of an erroring transfer. Their causes are: an offset that does not exist, a write to a read-only offset, or a read of a write-only offset. A read that errors returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| por_n | input | 1 | Asynchronous active-low power-on reset for the retained word |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address within the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Transfer error |
| err_pulse | output | 1 | One-cycle access-error indication |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench builds three copies side by side, one for each of the variant values 0, 1 and 2. Each copy has its own select line, and the copies share the rest of the bus. With all three copies present, one run can check the offsets that appear, vanish or change meaning between variants. For example, it can check the ID byte that differs, the reserved read-as-zero word of variant 0, and the sense words that exist in only one variant. Variant 2 adds the self-locking power-control word.

// File: rtl/sysctl_regfile.sv
module sysctl_regfile #(
  parameter int VARIANT = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        por_n,
  input  logic        psel,
  input  logic        penable,
  input  logic        pwrite,
  input  logic [11:0] paddr,
  input  logic [31:0] pwdata,
  output logic [31:0] prdata,
  output logic        pready,
  output logic        pslverr,
  output logic        err_pulse,
  output logic        sys_rst_req
);
  localparam bit V0  = (VARIANT == 0);
  localparam bit V1  = (VARIANT == 1);
  localparam bit V2  = (VARIANT == 2);
  localparam bit V12 = !V0;
  localparam logic [7:0] ID_REV = V0 ? 8'h0B : 8'h1B;
  localparam int RST_BIT = 9;

  logic [31:0] dbg_q, secc_q, fdiv_q, sdiv_q, cfrc_q, cause_q, mask_q, retain_q;
  logic [31:0] aux_q, pwr_q, s_sys_q, s_cpu_q, s_m0_q, s_m1_q, s_m2_q, s_m3_q;

  logic        acc, wr, rd;
  logic        hit, ro, wo, err_c;
  logic [31:0] rdat;
  logic [3:0]  id_sel;

  assign acc    = psel & penable;
  assign wr     = acc & pwrite;
  assign rd     = acc & ~pwrite;
  assign id_sel = paddr[5:2] - 4'd4;

  function automatic logic [7:0] id_byte(input logic [3:0] i);
    case (i)
      4'd0:  id_byte = 8'h04;
      4'd4:  id_byte = 8'h54;
      4'd5:  id_byte = 8'hB8;
      4'd6:  id_byte = ID_REV;
      4'd8:  id_byte = 8'h0D;
      4'd9:  id_byte = 8'hF0;
      4'd10: id_byte = 8'h05;
      4'd11: id_byte = 8'hB1;
      default: id_byte = 8'h00;
    endcase
  endfunction

  always_comb begin
    hit  = 1'b0;
    ro   = 1'b0;
    wo   = 1'b0;
    rdat = '0;
    case ({paddr[11:2], 2'b00})
      12'h000: begin hit = 1'b1; ro = 1'b1; rdat = dbg_q; end
      12'h004, 12'h008, 12'h108: begin hit = 1'b1; wo = 1'b1; end
      12'h00C: begin hit = V12; rdat = secc_q; end
      12'h010: begin hit = V12; rdat = fdiv_q; end
      12'h014: begin hit = V12; rdat = sdiv_q; end
      12'h018: begin hit = V12; rdat = cfrc_q; end
      12'h100: begin hit = 1'b1; rdat = cause_q; end
      12'h104: begin hit = 1'b1; rdat = mask_q; end
      12'h10C: begin hit = 1'b1; rdat = retain_q; end
      12'h11C: begin hit = V0 | V1; ro = V0; rdat = V1 ? aux_q : '0; end
      12'h1FC: begin hit = V2; rdat = pwr_q; end
      12'h200: begin hit = V12; rdat = s_sys_q; end
      12'h204: begin hit = V2; rdat = s_cpu_q; end
      12'h20C: begin hit = V1; rdat = s_m0_q; end
      12'h210: begin hit = V1; rdat = s_m1_q; end
      12'h214: begin hit = V12; rdat = s_m2_q; end
      12'h218: begin hit = V12; rdat = s_m3_q; end
      default: begin
        if (paddr[11:2] >= 10'h3F4) begin
          hit  = 1'b1;
          ro   = 1'b1;
          rdat = {24'h0, id_byte(id_sel)};
        end
      end
    endcase
  end

  assign err_c     = acc & (~hit | (pwrite & ro) | (~pwrite & wo));
  assign pslverr   = err_c;
  assign err_pulse = err_c;
  assign pready    = 1'b1;
  assign prdata    = (rd & ~err_c) ? rdat : '0;

  logic wen;
  assign wen = wr & hit & ~ro & ~wo;

  function automatic logic at(input logic [11:0] a, input logic [11:0] b);
    at = (a[11:2] == b[11:2]);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dbg_q <= '0; secc_q <= '0; fdiv_q <= '0; sdiv_q <= '0; cfrc_q <= '0;
      cause_q <= 32'h1; mask_q <= '0; aux_q <= '0; pwr_q <= 32'h3;
      s_sys_q <= 32'h7F; s_cpu_q <= '0; s_m0_q <= '0; s_m1_q <= '0;
      s_m2_q <= '0; s_m3_q <= '0; sys_rst_req <= 1'b0;
    end else begin
      sys_rst_req <= wr && at(paddr, 12'h108) && pwdata[RST_BIT];
      if (wr && at(paddr, 12'h004)) dbg_q <= dbg_q | pwdata;
      else if (wr && at(paddr, 12'h008)) dbg_q <= dbg_q & ~pwdata;
      if (wen) begin
        if (at(paddr, 12'h00C)) secc_q  <= pwdata;
        if (at(paddr, 12'h010)) fdiv_q  <= pwdata;
        if (at(paddr, 12'h014)) sdiv_q  <= pwdata;
        if (at(paddr, 12'h018)) cfrc_q  <= pwdata;
        if (at(paddr, 12'h100)) cause_q <= pwdata;
        if (at(paddr, 12'h104)) mask_q  <= pwdata;
        if (at(paddr, 12'h11C)) aux_q   <= pwdata;
        if (at(paddr, 12'h1FC) && pwr_q[0]) pwr_q <= pwdata;
        if (at(paddr, 12'h200)) s_sys_q <= pwdata;
        if (at(paddr, 12'h204)) s_cpu_q <= pwdata;
        if (at(paddr, 12'h20C)) s_m0_q  <= pwdata;
        if (at(paddr, 12'h210)) s_m1_q  <= pwdata;
        if (at(paddr, 12'h214)) s_m2_q  <= pwdata;
        if (at(paddr, 12'h218)) s_m3_q  <= pwdata;
      end
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) retain_q <= '0;
    else if (wen && at(paddr, 12'h10C)) retain_q <= pwdata;
  end
endmodule

// File: rtl/sysctl_regfile_chk.sv
module sysctl_regfile_chk #(
  parameter int VARIANT = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        por_n,
  input logic        psel,
  input logic        penable,
  input logic        pwrite,
  input logic [11:0] paddr,
  input logic [31:0] pwdata,
  input logic [31:0] prdata,
  input logic        pslverr,
  input logic        err_pulse,
  input logic        sys_rst_req,
  input logic [31:0] dbg_q,
  input logic [31:0] pwr_q,
  input logic [31:0] retain_q
);
  logic wr_acc;
  assign wr_acc = psel && penable && pwrite;

  // R4
  rst_req_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> $past(wr_acc && paddr[11:2] == 10'h042 && pwdata[9]));

  // R4
  rst_req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |=> !sys_rst_req);

  // R2
  dbg_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && paddr[11:2] == 10'h001) |=> ((dbg_q & $past(pwdata)) == $past(pwdata)));

  // R2
  dbg_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && paddr[11:2] == 10'h002) |=> ((dbg_q & $past(pwdata)) == 32'h0));

  // R6
  pwr_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_q[0] |=> $stable(pwr_q));

  // R5
  retain_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    !(wr_acc && paddr[11:2] == 10'h043) |=> $stable(retain_q));

  // R12
  err_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pslverr && !pwrite) |-> prdata == 32'h0);

  // R12
  err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |=> !err_pulse);
endmodule

bind sysctl_regfile sysctl_regfile_chk #(.VARIANT(VARIANT)) chk_i (
  .clk(clk), .rst_n(rst_n), .por_n(por_n), .psel(psel), .penable(penable),
  .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
  .pslverr(pslverr), .err_pulse(err_pulse), .sys_rst_req(sys_rst_req),
  .dbg_q(dbg_q), .pwr_q(pwr_q), .retain_q(retain_q)
);

// File: tb/sysctl_regfile_tb_top.sv
`timescale 1ns/1ps
module sysctl_regfile_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0, por_n = 1'b0;
  logic [2:0] sel = '0;
  logic penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] rdat [3];
  logic rdy [3], serr [3], eerr [3], rq [3];
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sysctl_regfile #(.VARIANT(0)) dut_v0_i (.clk(clk), .rst_n(rst_n), .por_n(por_n),
    .psel(sel[0]), .penable(penable), .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
    .prdata(rdat[0]), .pready(rdy[0]), .pslverr(serr[0]), .err_pulse(eerr[0]), .sys_rst_req(rq[0]));
  sysctl_regfile #(.VARIANT(1)) dut_v1_i (.clk(clk), .rst_n(rst_n), .por_n(por_n),
    .psel(sel[1]), .penable(penable), .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
    .prdata(rdat[1]), .pready(rdy[1]), .pslverr(serr[1]), .err_pulse(eerr[1]), .sys_rst_req(rq[1]));
  sysctl_regfile #(.VARIANT(2)) dut_i (.clk(clk), .rst_n(rst_n), .por_n(por_n),
    .psel(sel[2]), .penable(penable), .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
    .prdata(rdat[2]), .pready(rdy[2]), .pslverr(serr[2]), .err_pulse(eerr[2]), .sys_rst_req(rq[2]));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus(input int v, input bit w, input logic [11:0] a, input logic [31:0] d,
                     output logic [31:0] rd, output logic er);
    @(negedge clk);
    sel = 3'b001 << v; pwrite = w; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    #1;
    rd = rdat[v]; er = serr[v];
    if (eerr[v] !== serr[v]) check("R12 err_pulse", {31'h0, eerr[v]}, {31'h0, serr[v]});
    @(negedge clk);
    sel = '0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic expect_rd(input string req, input int v, input logic [11:0] a,
                           input logic [31:0] exp, input logic exp_err);
    logic [31:0] d; logic e;
    bus(v, 1'b0, a, '0, d, e);
    check(req, d, exp);
    check({req, " err"}, {31'h0, e}, {31'h0, exp_err});
  endtask

  task automatic expect_wr(input string req, input int v, input logic [11:0] a,
                           input logic [31:0] d, input logic exp_err);
    logic [31:0] r; logic e;
    bus(v, 1'b1, a, d, r, e);
    check({req, " werr"}, {31'h0, e}, {31'h0, exp_err});
  endtask

  task automatic t_reset_values();
    expect_rd("R1 cause", 2, 12'h100, 32'h1, 1'b0);
    expect_rd("R1 pwr", 2, 12'h1FC, 32'h3, 1'b0);
    expect_rd("R1 sense", 1, 12'h200, 32'h7F, 1'b0);
    expect_rd("R1 dbg", 2, 12'h000, 32'h0, 1'b0);
    expect_rd("R1 mask", 2, 12'h104, 32'h0, 1'b0);
    check("R1 rst_req idle", {31'h0, rq[2]}, 32'h0);
  endtask

  task automatic t_debug();
    expect_wr("R2 set", 2, 12'h004, 32'h0000_F0F0, 1'b0);
    expect_wr("R2 set", 2, 12'h004, 32'h0000_000F, 1'b0);
    expect_rd("R2 or", 2, 12'h000, 32'h0000_F0FF, 1'b0);
    expect_wr("R2 clr", 2, 12'h008, 32'h0000_00F0, 1'b0);
    expect_rd("R2 clr", 2, 12'h000, 32'h0000_F00F, 1'b0);
    expect_wr("R2 ro", 2, 12'h000, 32'hFFFF_FFFF, 1'b1);
    expect_rd("R2 ro kept", 2, 12'h000, 32'h0000_F00F, 1'b0);
  endtask

  task automatic t_write_only();
    expect_rd("R3 set alias", 2, 12'h004, 32'h0, 1'b1);
    expect_rd("R3 clr alias", 0, 12'h008, 32'h0, 1'b1);
    expect_rd("R3 swreset", 1, 12'h108, 32'h0, 1'b1);
  endtask

  task automatic t_swreset();
    expect_wr("R4 req", 2, 12'h108, 32'h0000_0200, 1'b0);
    check("R4 pulse high", {31'h0, rq[2]}, 32'h1);
    @(negedge clk);
    check("R4 pulse low", {31'h0, rq[2]}, 32'h0);
    expect_wr("R4 other bits", 2, 12'h108, 32'hFFFF_FDFF, 1'b0);
    check("R4 no pulse", {31'h0, rq[2]}, 32'h0);
  endtask

  task automatic t_retention();
    expect_wr("R5 wr", 2, 12'h10C, 32'hA5A5_1234, 1'b0);
    expect_wr("R5 cause wr", 2, 12'h100, 32'h0000_0004, 1'b0);
    @(negedge clk); rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    expect_rd("R5 kept", 2, 12'h10C, 32'hA5A5_1234, 1'b0);
    expect_rd("R5 cause reset", 2, 12'h100, 32'h1, 1'b0);
    expect_rd("R5 dbg reset", 2, 12'h000, 32'h0, 1'b0);
    @(negedge clk); por_n = 1'b0; @(negedge clk); por_n = 1'b1;
    expect_rd("R5 por clears", 2, 12'h10C, 32'h0, 1'b0);
  endtask

  task automatic t_lock();
    expect_wr("R6 unlocked", 2, 12'h1FC, 32'h0000_0002, 1'b0);
    expect_rd("R6 stored", 2, 12'h1FC, 32'h0000_0002, 1'b0);
    expect_wr("R6 locked", 2, 12'h1FC, 32'h0000_00FF, 1'b0);
    expect_rd("R6 dropped", 2, 12'h1FC, 32'h0000_0002, 1'b0);
    expect_rd("R10 pwr v1 absent", 1, 12'h1FC, 32'h0, 1'b1);
  endtask

  task automatic t_ids();
    expect_rd("R7 first", 2, 12'hFD0, 32'h04, 1'b0);
    expect_rd("R7 pid0", 0, 12'hFE0, 32'h54, 1'b0);
    expect_rd("R7 pid1", 1, 12'hFE4, 32'hB8, 1'b0);
    expect_rd("R7 rev v0", 0, 12'hFE8, 32'h0B, 1'b0);
    expect_rd("R7 rev v2", 2, 12'hFE8, 32'h1B, 1'b0);
    expect_rd("R7 cid0", 2, 12'hFF0, 32'h0D, 1'b0);
    expect_rd("R7 last", 2, 12'hFFC, 32'hB1, 1'b0);
    expect_wr("R7 ro", 2, 12'hFEC, 32'h55, 1'b1);
    expect_rd("R7 ro kept", 2, 12'hFEC, 32'h00, 1'b0);
  endtask

  task automatic t_v0_missing();
    expect_rd("R8 fdiv", 0, 12'h010, 32'h0, 1'b1);
    expect_wr("R8 sense wr", 0, 12'h200, 32'h1234, 1'b1);
    expect_rd("R8 sense rd", 0, 12'h200, 32'h0, 1'b1);
    expect_wr("R8 secc wr", 0, 12'h00C, 32'h1, 1'b1);
    expect_rd("R9 rd", 0, 12'h11C, 32'h0, 1'b0);
    expect_wr("R9 wr", 0, 12'h11C, 32'hFFFF_FFFF, 1'b1);
    expect_rd("R9 rd after", 0, 12'h11C, 32'h0, 1'b0);
  endtask

  task automatic t_variant_map();
    expect_wr("R10 m0 v1", 1, 12'h20C, 32'h0000_0011, 1'b0);
    expect_rd("R10 m0 v1", 1, 12'h20C, 32'h0000_0011, 1'b0);
    expect_rd("R10 m0 v2", 2, 12'h20C, 32'h0, 1'b1);
    expect_wr("R10 cpu v2", 2, 12'h204, 32'h0000_0022, 1'b0);
    expect_rd("R10 cpu v2", 2, 12'h204, 32'h0000_0022, 1'b0);
    expect_rd("R10 cpu v1", 1, 12'h204, 32'h0, 1'b1);
    expect_wr("R10 m3 v2", 2, 12'h218, 32'h0000_0033, 1'b0);
    expect_rd("R10 m3 v2", 2, 12'h218, 32'h0000_0033, 1'b0);
    expect_rd("R10 m2 v0", 0, 12'h214, 32'h0, 1'b1);
    expect_wr("R10 aux v1", 1, 12'h11C, 32'h0000_0044, 1'b0);
    expect_rd("R10 aux v1", 1, 12'h11C, 32'h0000_0044, 1'b0);
    expect_rd("R10 aux v2", 2, 12'h11C, 32'h0, 1'b1);
    expect_rd("R12 hole", 2, 12'h400, 32'h0, 1'b1);
  endtask

  task automatic t_storage();
    expect_wr("R11 fdiv", 1, 12'h010, 32'hDEAD_BEEF, 1'b0);
    expect_rd("R11 fdiv", 1, 12'h010, 32'hDEAD_BEEF, 1'b0);
    expect_wr("R11 cfrc", 2, 12'h018, 32'h0000_0101, 1'b0);
    expect_rd("R11 cfrc", 2, 12'h018, 32'h0000_0101, 1'b0);
    expect_wr("R11 mask", 0, 12'h104, 32'h8000_0001, 1'b0);
    expect_rd("R11 mask", 0, 12'h104, 32'h8000_0001, 1'b0);
    check("R12 idle no err", {31'h0, serr[2]}, 32'h0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1; por_n = 1'b1;
    t_reset_values();
    t_debug();
    t_write_only();
    t_swreset();
    t_retention();
    t_lock();
    t_ids();
    t_v0_missing();
    t_variant_map();
    t_storage();
    finish_run();
  end
endmodule